// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block watches every bus cycle started by the CPU or a DMA engine. It raises a break interrupt request when a cycle meets a condition that software has programmed. The condition has four parts: the kind of cycle (instruction fetch or data access), the direction (read or write), the operand size, and a masked address compare. All of them must be met in the same cycle. A match sets a sticky break flag one clock later. The interrupt request follows that flag.

Software programs the condition through a simple write port. That port has a 2-bit register select. Select 0 is the control register. Select 1 is the compare address. Select 2 is the address mask. A write to select 3 with bit 0 set to 1 clears the flag. Instruction fetches are always treated as word accesses. The size compared is the logical operand size of the access, not the width of the memory space being addressed.

Top module: `bus_brk_matcher`

## Requirements
- R1: After reset the control fields, compare address and mask are all zero, and `brk_flag` and `brk_irq` are low. With those values no bus cycle sets the flag.
- R2: Control bits [5:4] select the cycle kind. 00 gives no break, 01 matches fetches (`cyc_ifetch`=1), 10 matches data accesses (`cyc_ifetch`=0), and 11 matches both.
- R3: Control bits [3:2] select the direction. 00 gives no break, 01 matches reads (`cyc_write`=0), 10 matches writes (`cyc_write`=1), and 11 matches both.
- R4: Control bits [1:0] select the size. 00 means size is ignored, 01 is byte, 10 is word, and 11 is longword. A data cycle matches when `cyc_size` uses the same code.
- R5: An instruction fetch always counts as a word access, whatever `cyc_size` carries. A fetch therefore matches size codes 00 and 10 only.
- R6: The address part holds when ((`cyc_addr` ^ compare) & ~mask) == 0. A mask bit set to 1 makes that address bit don't-care.
- R7: The flag rises on the clock edge that samples a matching cycle with `cyc_vld`=1. It does not rise without such a cycle.
- R8: The flag stays set until software writes select 3 with bit 0 set to 1. A write to select 3 with bit 0 at 0 has no effect.
- R9: When a match and a clear fall on the same edge, the flag stays set.
- R10: `brk_irq` always equals `brk_flag`.
- R11: Rewriting the control, compare or mask registers does not clear a pending flag.
- R12: A register write takes effect from the edge on which it is sampled. A bus cycle on that same edge is judged against the old condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| cyc_vld | input | 1 | One bus cycle is presented in this clock |
| cyc_addr | input | AW | Address of the cycle |
| cyc_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 compare, 2 mask, 3 flag clear |
| cfg_wdata | input | AW | Write data |
| brk_flag | output | 1 | Sticky break flag |
| brk_irq | output | 1 | Break interrupt request |

## Verification
Each code of the cycle-kind field is tried with both fetch and data cycles. This separates the four codes and shows that 00 blocks every cycle. The direction field is tried the same way with reads and writes. Data cycles of all three sizes are run against each size code, and fetches that carry a byte or longword `cyc_size` show that fetch sizing does not depend on that input. Address patterns that differ inside and outside the masked bits separate the don't-care bits from the compared ones. Clear writes are placed alone, together with a match, and with bit 0 at zero; these tell the hold, clear and set-wins behaviour apart.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] dir;
    logic [1:0] size;
  } brk_ctrl_t;

  localparam logic [1:0] SZ_ANY  = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMP  = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

  localparam int CTRL_W = $bits(brk_ctrl_t);
endpackage

// File: rtl/brk_cond_match.sv
module brk_cond_match
  import brk_pkg::*;
(
  input  brk_ctrl_t  ctrl,
  input  logic       ifetch,
  input  logic       write,
  input  logic [1:0] size,
  output logic       cond_ok
);
  logic       kind_ok;
  logic       dir_ok;
  logic [1:0] eff_size;
  logic       size_ok;

  always_comb begin
    kind_ok  = ifetch ? ctrl.kind[0] : ctrl.kind[1];
    dir_ok   = write  ? ctrl.dir[1]  : ctrl.dir[0];
    eff_size = ifetch ? SZ_WORD : size;
    size_ok  = (ctrl.size == SZ_ANY) || (ctrl.size == eff_size);
    cond_ok  = kind_ok && dir_ok && size_ok;
  end
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] cmp,
  input  logic [AW-1:0] mask,
  output logic          addr_ok
);
  logic [AW-1:0] bit_ok;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = mask[i] || (addr[i] == cmp[i]);
  end

  assign addr_ok = &bit_ok;
endmodule

// File: rtl/brk_flag_reg.sv
module brk_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = hit || clr;
    flag_d  = hit ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  p_set_after_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr && !hit) |=> !flag);
  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/bus_brk_matcher.sv
module bus_brk_matcher
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_vld,
  input  logic [AW-1:0] cyc_addr,
  input  logic          cyc_ifetch,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_size,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          brk_flag,
  output logic          brk_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  brk_ctrl_t     ctrl_q,  ctrl_d;
  logic [AW-1:0] cmp_q,   cmp_d;
  logic [AW-1:0] mask_q,  mask_d;
  logic          ctrl_en, cmp_en, mask_en, clr;

  always_comb begin
    ctrl_en = cfg_we && (cfg_sel == SEL_CTRL);
    cmp_en  = cfg_we && (cfg_sel == SEL_CMP);
    mask_en = cfg_we && (cfg_sel == SEL_MASK);
    clr     = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];
    ctrl_d  = brk_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    cmp_d   = cfg_wdata;
    mask_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cmp_en)  cmp_q  <= cmp_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  logic cond_ok, addr_ok, hit;

  brk_cond_match u_cond (
    .ctrl    (ctrl_q),
    .ifetch  (cyc_ifetch),
    .write   (cyc_write),
    .size    (cyc_size),
    .cond_ok (cond_ok)
  );

  brk_addr_cmp #(.AW(AW)) u_addr (
    .addr    (cyc_addr),
    .cmp     (cmp_q),
    .mask    (mask_q),
    .addr_ok (addr_ok)
  );

  assign hit = cyc_vld && cond_ok && addr_ok;

  brk_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n_int),
    .hit   (hit),
    .clr   (clr),
    .flag  (brk_flag)
  );

  assign brk_irq = brk_flag;

  p_idle_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cyc_vld |=> !$rose(brk_flag));
  p_kind_off_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cyc_vld && ctrl_q.kind == 2'b00) |=> !$rose(brk_flag));
  p_dir_off_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cyc_vld && ctrl_q.dir == 2'b00) |=> !$rose(brk_flag));
  p_fetch_byte_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cyc_vld && cyc_ifetch && ctrl_q.size == SZ_BYTE) |=> !$rose(brk_flag));
  p_cfg_keeps_flag_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (brk_flag && cfg_we && cfg_sel != SEL_CLR) |=> brk_flag);
endmodule

// File: tb/bus_brk_matcher_tb_top.sv
module bus_brk_matcher_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_vld = 1'b0;
  logic [AW-1:0] cyc_addr = '0;
  logic          cyc_ifetch = 1'b0;
  logic          cyc_write = 1'b0;
  logic [1:0]    cyc_size = 2'b00;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'b00;
  logic [AW-1:0] cfg_wdata = '0;
  logic          brk_flag, brk_irq;

  int tests = 0;
  int fails = 0;

  logic [5:0]    m_ctrl = '0;
  logic [AW-1:0] m_cmp = '0;
  logic [AW-1:0] m_mask = '0;
  logic          m_flag = 1'b0;

  always #5 clk = ~clk;

  bus_brk_matcher #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_addr(cyc_addr),
    .cyc_ifetch(cyc_ifetch), .cyc_write(cyc_write), .cyc_size(cyc_size),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .brk_flag(brk_flag), .brk_irq(brk_irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_hit();
    logic k, d, s;
    logic [1:0] es;
    k  = cyc_ifetch ? m_ctrl[4] : m_ctrl[5];
    d  = cyc_write ? m_ctrl[3] : m_ctrl[2];
    es = cyc_ifetch ? 2'b10 : cyc_size;
    s  = (m_ctrl[1:0] == 2'b00) || (m_ctrl[1:0] == es);
    return cyc_vld && k && d && s && (((cyc_addr ^ m_cmp) & ~m_mask) == '0);
  endfunction

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic step(input string tag, input logic v, input logic [AW-1:0] a,
                      input logic f, input logic w, input logic [1:0] sz,
                      input logic we, input logic [1:0] sel, input logic [AW-1:0] wd);
    logic h, c;
    cyc_vld = v; cyc_addr = a; cyc_ifetch = f; cyc_write = w; cyc_size = sz;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(posedge clk);
    h = model_hit();
    c = we && sel == 2'd3 && wd[0];
    m_flag = h | (m_flag & ~c);
    if (we && sel == 2'd0) m_ctrl = wd[5:0];
    if (we && sel == 2'd1) m_cmp  = wd;
    if (we && sel == 2'd2) m_mask = wd;
    #2;
    check(tag, brk_flag, m_flag);
    check("R10", brk_irq, brk_flag);
    @(negedge clk);
    cyc_vld = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [AW-1:0] d);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 2'b00, 1'b1, sel, d);
  endtask

  task automatic bus(input string tag, input logic [AW-1:0] a, input logic f,
                     input logic w, input logic [1:0] sz);
    step(tag, 1'b1, a, f, w, sz, 1'b0, 2'd0, '0);
  endtask

  task automatic clear(input string tag);
    wr(tag, 2'd3, 32'h1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", brk_flag, 1'b0);
    check("R1", brk_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset configuration matches nothing
    bus("R1", 32'h0, 1'b1, 1'b0, 2'b10);
    bus("R1", 32'h0, 1'b0, 1'b1, 2'b11);

    // R6: open mask, everything allowed
    wr("R6", 2'd2, 32'hFFFF_FFFF);
    wr("R2", 2'd0, 32'h3C);
    bus("R7", 32'h1234, 1'b0, 1'b0, 2'b01);
    wr("R8", 2'd3, 32'h0);
    wr("R11", 2'd0, 32'h00);
    bus("R8", 32'h0, 1'b0, 1'b0, 2'b01);
    clear("R8");
    step("R7", 1'b0, 32'h0, 1'b0, 1'b0, 2'b01, 1'b0, 2'd0, '0);

    // R2: kind field codes
    for (int k = 0; k < 4; k++) begin
      wr("R2", 2'd0, 32'(k << 4) | 32'h0C);
      bus("R2", 32'h0, 1'b1, 1'b0, 2'b10); clear("R2");
      bus("R2", 32'h0, 1'b0, 1'b0, 2'b10); clear("R2");
    end
    // R3: direction field codes
    for (int d = 0; d < 4; d++) begin
      wr("R3", 2'd0, 32'h30 | 32'(d << 2));
      bus("R3", 32'h0, 1'b0, 1'b0, 2'b11); clear("R3");
      bus("R3", 32'h0, 1'b0, 1'b1, 2'b11); clear("R3");
    end
    // R4 / R5: size codes vs data sizes and fetches
    for (int s = 0; s < 4; s++) begin
      wr("R4", 2'd0, 32'h3C | 32'(s));
      for (int z = 1; z < 4; z++) begin
        bus("R4", 32'h0, 1'b0, 1'b0, 2'(z)); clear("R4");
      end
      bus("R5", 32'h0, 1'b1, 1'b0, 2'b01); clear("R5");
      bus("R5", 32'h0, 1'b1, 1'b0, 2'b11); clear("R5");
    end

    // R6: masked address compare
    wr("R6", 2'd0, 32'h3C);
    wr("R6", 2'd1, 32'h0000_1000);
    wr("R6", 2'd2, 32'h0000_000F);
    bus("R6", 32'h0000_100A, 1'b0, 1'b0, 2'b01); clear("R6");
    bus("R6", 32'h0000_1010, 1'b0, 1'b0, 2'b01); clear("R6");
    bus("R6", 32'h8000_1000, 1'b0, 1'b0, 2'b01); clear("R6");
    bus("R6", 32'h0000_1000, 1'b1, 1'b1, 2'b10); clear("R6");

    // R9: match and clear together
    bus("R9", 32'h0000_1001, 1'b0, 1'b0, 2'b01);
    step("R9", 1'b1, 32'h0000_1001, 1'b0, 1'b0, 2'b01, 1'b1, 2'd3, 32'h1);
    clear("R9");

    // R12: config write and bus cycle on same edge use old condition
    step("R12", 1'b1, 32'h0000_1002, 1'b0, 1'b0, 2'b01, 1'b1, 2'd0, 32'h0);
    clear("R12");
    step("R12", 1'b1, 32'h0000_1002, 1'b0, 1'b0, 2'b01, 1'b1, 2'd0, 32'h3C);
    bus("R12", 32'h0000_1002, 1'b0, 1'b0, 2'b01);

    // R11: rewrite all config while flag pending
    wr("R11", 2'd1, 32'hFFFF_0000);
    wr("R11", 2'd2, 32'h0);
    wr("R11", 2'd0, 32'h0);
    bus("R11", 32'h0, 1'b0, 1'b0, 2'b01);
    clear("R8");
    bus("R1", 32'h0, 1'b0, 1'b0, 2'b01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule